// File: doc/BRIEF.md
# Dual-Rail Complement Checker with Cascaded Error Line

This block watches signals carried in dual-rail form, where every logical bit travels on two wires that must always hold opposite values. It offers two independent checking paths that work side by side. The first is a classic two-rail cell. It takes two rail pairs and folds them into a two-wire result, which stays complementary only while both input pairs are complementary. A flag is raised when the two result wires agree.

The second path is a reduced, single-line checker. Each monitored pair is first collapsed to one bit by an XOR of its rails. An implication stage then folds that bit into a running error line. `NPAIR` such stages are chained in series. The first stage starts from a constant 0, so the line leaving the last stage rises exactly when any pair in the chain has equal rails. The value after every stage is also brought out. This shows how far along the chain the first bad pair sits.

All outputs are registered once, so both paths report the verdict for the inputs present at one rising clock edge right after that edge. Producing the dual-rail signals themselves is the job of the surrounding logic.

Top module: `dual_rail_check_chain`

## Requirements
- R1: A rising clock edge with `rst` high clears `cell_e1_o`, `cell_e2_o`, `cell_err_o`, `stage_o` and `chain_err_o` to 0.
- R2: Pair encoding of the cell: bit 1 of `cell_p0_i` is x0 and bit 0 is y0; bit 1 of `cell_p1_i` is x1 and bit 0 is y1. After each edge, `cell_e1_o` = (x0 & y1) | (y0 & x1) and `cell_e2_o` = (x0 & x1) | (y0 & y1), computed from the inputs sampled at that edge.
- R3: When both cell pairs are complementary (x0 != y0 and x1 != y1), `cell_e2_o` is the inverse of `cell_e1_o` and `cell_err_o` is 0.
- R4: `cell_err_o` is 1 after an edge exactly when the two cell outputs computed from the sampled inputs are equal. In particular, any cell pair whose rails are equal raises it.
- R5: Chain pair i is made of `chain_hi_i[i]` and `chain_lo_i[i]`. It counts as valid when these two bits differ. A valid pair passes the incoming line value through its stage unchanged.
- R6: Stage 0 receives a constant 0 as its incoming line. After each edge, `stage_o[k]` is 1 exactly when at least one of pairs 0..k had equal rails at that edge.
- R7: `chain_err_o` is 1 after an edge exactly when at least one of the `NPAIR` pairs had equal rails. It is 0 when every pair is valid.
- R8: The two paths are independent. A bad cell pair never affects `stage_o` or `chain_err_o`, and a bad chain pair never affects the cell outputs, including when both occur at the same edge.
- R9: `NPAIR` is a parameter with a default of 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cell_p0_i | input | 2 | First cell pair: bit 1 = x0, bit 0 = y0 |
| cell_p1_i | input | 2 | Second cell pair: bit 1 = x1, bit 0 = y1 |
| chain_hi_i | input | NPAIR | First rail of each chain pair |
| chain_lo_i | input | NPAIR | Second rail of each chain pair |
| cell_e1_o | output | 1 | First wire of the cell's two-rail result |
| cell_e2_o | output | 1 | Second wire of the cell's two-rail result |
| cell_err_o | output | 1 | Cell result wires agree (error) |
| stage_o | output | NPAIR | Error line value after each chain stage |
| chain_err_o | output | 1 | Error line leaving the last stage |

## Verification
The cell error and the chain error can both be raised at the same clock edge. The bench provokes this by driving a non-complementary cell pair together with one or more non-complementary chain pairs in one cycle. It also drives a bad pair on one path while the other path carries only valid pairs. On every clock, a behavioural model compares each flag, the per-stage taps and both cell wires. A fault that leaks from one path into the other, or that masks one flag when both paths fail, shows up as a mismatch in that cycle.

// File: rtl/dual_rail_pkg.sv
package dual_rail_pkg;

    // One dual-rail signal: the two wires must hold opposite values.
    typedef struct packed {
        logic hi;
        logic lo;
    } rail_pair_t;

    // Two-wire result of the classic cell.
    typedef struct packed {
        logic e1;
        logic e2;
    } rail_out_t;

    // Collapse a pair to one bit: 1 when the rails differ.
    function automatic logic pair_merge(rail_pair_t p);
        return p.hi ^ p.lo;
    endfunction

    // Implication stage: ~a | c.
    function automatic logic implies_or(logic a, logic c);
        return (~a) | c;
    endfunction

    // Classic two-rail combination of pair a (x0,y0) and pair b (x1,y1).
    function automatic rail_out_t rail_combine(rail_pair_t a, rail_pair_t b);
        rail_out_t r;
        r.e1 = (a.hi & b.lo) | (a.lo & b.hi);
        r.e2 = (a.hi & b.hi) | (a.lo & b.lo);
        return r;
    endfunction

endpackage

// File: rtl/two_rail_cell.sv
module two_rail_cell
    import dual_rail_pkg::*;
(
    input  rail_pair_t pa,
    input  rail_pair_t pb,
    output rail_out_t  res,
    output logic       bad
);
    rail_out_t comb;

    always_comb begin
        comb = rail_combine(pa, pb);
        res  = comb;
        bad  = ~(comb.e1 ^ comb.e2);
    end
endmodule

// File: rtl/reduce_stage.sv
module reduce_stage
    import dual_rail_pkg::*;
(
    input  rail_pair_t pair,
    input  logic       line_in,
    output logic       line_out
);
    logic merged;

    always_comb begin
        merged   = pair_merge(pair);
        line_out = implies_or(merged, line_in);
    end
endmodule

// File: rtl/reduce_chain.sv
module reduce_chain
    import dual_rail_pkg::*;
#(
    parameter int NPAIR = 3
) (
    input  logic [NPAIR-1:0] hi,
    input  logic [NPAIR-1:0] lo,
    output logic [NPAIR-1:0] taps
);
    localparam int NLINE = NPAIR + 1;

    logic [NLINE-1:0] line;

    assign line[0] = 1'b0;

    for (genvar k = 0; k < NPAIR; k++) begin : g_stage
        rail_pair_t pk;
        assign pk.hi = hi[k];
        assign pk.lo = lo[k];

        reduce_stage u_stage (
            .pair    (pk),
            .line_in (line[k]),
            .line_out(line[k+1])
        );

        assign taps[k] = line[k+1];
    end
endmodule

// File: rtl/dual_rail_check_chain.sv
module dual_rail_check_chain
    import dual_rail_pkg::*;
#(
    parameter int NPAIR = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cell_p0_i,
    input  logic [1:0]       cell_p1_i,
    input  logic [NPAIR-1:0] chain_hi_i,
    input  logic [NPAIR-1:0] chain_lo_i,
    output logic             cell_e1_o,
    output logic             cell_e2_o,
    output logic             cell_err_o,
    output logic [NPAIR-1:0] stage_o,
    output logic             chain_err_o
);
    localparam int LAST = NPAIR - 1;

    rail_pair_t       pa, pb;
    rail_out_t        cell_res;
    logic             cell_bad;
    logic [NPAIR-1:0] taps;

    assign pa = rail_pair_t'(cell_p0_i);
    assign pb = rail_pair_t'(cell_p1_i);

    two_rail_cell u_cell (
        .pa (pa),
        .pb (pb),
        .res(cell_res),
        .bad(cell_bad)
    );

    reduce_chain #(.NPAIR(NPAIR)) u_chain (
        .hi  (chain_hi_i),
        .lo  (chain_lo_i),
        .taps(taps)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cell_e1_o   <= 1'b0;
            cell_e2_o   <= 1'b0;
            cell_err_o  <= 1'b0;
            stage_o     <= '0;
            chain_err_o <= 1'b0;
        end else begin
            cell_e1_o   <= cell_res.e1;
            cell_e2_o   <= cell_res.e2;
            cell_err_o  <= cell_bad;
            stage_o     <= taps;
            chain_err_o <= taps[LAST];
        end
    end
endmodule

// File: rtl/dual_rail_chk.sv
module dual_rail_chk #(
    parameter int NPAIR = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       cell_p0_i,
    input logic [1:0]       cell_p1_i,
    input logic [NPAIR-1:0] chain_hi_i,
    input logic [NPAIR-1:0] chain_lo_i,
    input logic             cell_e1_o,
    input logic             cell_e2_o,
    input logic             cell_err_o,
    input logic [NPAIR-1:0] stage_o,
    input logic             chain_err_o
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R1
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!cell_e1_o && !cell_e2_o && !cell_err_o && stage_o == '0 && !chain_err_o));

    // R3
    assert_cell_complement_R3: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(cell_p0_i[1] != cell_p0_i[0]) && $past(cell_p1_i[1] != cell_p1_i[0]))
        |-> (cell_e1_o != cell_e2_o && !cell_err_o));

    // R4
    assert_cell_bad_pair_R4: assert property (@(posedge clk) disable iff (rst)
        (past_ok && ($past(cell_p0_i[1] == cell_p0_i[0]) || $past(cell_p1_i[1] == cell_p1_i[0])))
        |-> cell_err_o);

    // R7
    assert_chain_clean_R7: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past((chain_hi_i ^ chain_lo_i) == {NPAIR{1'b1}})) |-> !chain_err_o);

    // R7
    assert_chain_any_R7: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past((chain_hi_i ^ chain_lo_i) != {NPAIR{1'b1}})) |-> chain_err_o);

    // R6: once the line is raised it stays raised further down the chain
    assert_stage_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        ((stage_o << 1) & ~stage_o) == '0);

    // R6: stage 0 reflects only pair 0
    assert_stage_first_R6: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (stage_o[0] == $past(chain_hi_i[0] == chain_lo_i[0])));
endmodule

bind dual_rail_check_chain dual_rail_chk #(.NPAIR(NPAIR)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cell_p0_i  (cell_p0_i),
    .cell_p1_i  (cell_p1_i),
    .chain_hi_i (chain_hi_i),
    .chain_lo_i (chain_lo_i),
    .cell_e1_o  (cell_e1_o),
    .cell_e2_o  (cell_e2_o),
    .cell_err_o (cell_err_o),
    .stage_o    (stage_o),
    .chain_err_o(chain_err_o)
);

// File: tb/sim_dual_rail_check_chain.sv
`timescale 1ns/1ps
module sim_dual_rail_check_chain;
    localparam int NP = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cell_p0_i = 2'b10;
    logic [1:0]    cell_p1_i = 2'b10;
    logic [NP-1:0] chain_hi_i = '1;
    logic [NP-1:0] chain_lo_i = '0;
    logic          cell_e1_o, cell_e2_o, cell_err_o, chain_err_o;
    logic [NP-1:0] stage_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    dual_rail_check_chain #(.NPAIR(NP)) u0 (
        .clk(clk), .rst(rst),
        .cell_p0_i(cell_p0_i), .cell_p1_i(cell_p1_i),
        .chain_hi_i(chain_hi_i), .chain_lo_i(chain_lo_i),
        .cell_e1_o(cell_e1_o), .cell_e2_o(cell_e2_o), .cell_err_o(cell_err_o),
        .stage_o(stage_o), .chain_err_o(chain_err_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural model: apply one input set, wait one edge, compare all outputs.
    task automatic step(input logic [1:0] p0, input logic [1:0] p1,
                        input logic [NP-1:0] hi, input logic [NP-1:0] lo);
        logic e1, e2, eerr;
        logic [NP-1:0] stg;
        bit seen;
        cell_p0_i  = p0;
        cell_p1_i  = p1;
        chain_hi_i = hi;
        chain_lo_i = lo;
        e1   = (p0[1] & p1[0]) | (p0[0] & p1[1]);
        e2   = (p0[1] & p1[1]) | (p0[0] & p1[0]);
        eerr = (e1 == e2);
        seen = 0;
        for (int k = 0; k < NP; k++) begin
            if (hi[k] == lo[k]) seen = 1;
            stg[k] = seen;
        end
        @(posedge clk);
        @(negedge clk);
        check("R2 e1", int'(cell_e1_o), int'(e1));
        check("R2 e2", int'(cell_e2_o), int'(e2));
        if (p0[1] != p0[0] && p1[1] != p1[0])
            check("R3 complement", int'(cell_e1_o ^ cell_e2_o), 1);
        check("R4 cell_err", int'(cell_err_o), int'(eerr));
        check("R6 stage taps", int'(stage_o), int'(stg));
        check("R7 chain_err", int'(chain_err_o), int'(seen));
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 e1", int'(cell_e1_o), 0);
        check("R1 e2", int'(cell_e2_o), 0);
        check("R1 cell_err", int'(cell_err_o), 0);
        check("R1 stage", int'(stage_o), 0);
        check("R1 chain_err", int'(chain_err_o), 0);
        check("R9 width", $bits(stage_o), 3);
        rst = 1'b0;

        // R5/R7: all valid, several patterns
        step(2'b10, 2'b01, 3'b101, 3'b010);
        step(2'b01, 2'b10, 3'b000, 3'b111);
        step(2'b10, 2'b10, 3'b111, 3'b000);

        // R6: one bad pair at each position, first and last stage included
        for (int k = 0; k < NP; k++) begin
            logic [NP-1:0] lo;
            lo = 3'b010;
            lo[k] = ~lo[k];
            step(2'b01, 2'b01, 3'b101 ^ 3'b000, lo ^ 3'b000);
        end
        step(2'b10, 2'b01, 3'b000, 3'b000);   // all bad, rails 0
        step(2'b10, 2'b01, 3'b111, 3'b111);   // all bad, rails 1

        // R2/R4: every cell input combination, chain clean (R8)
        for (int v = 0; v < 16; v++)
            step(v[3:2], v[1:0], 3'b110, 3'b001);

        // R8: both paths bad at one edge, and each alone
        step(2'b11, 2'b10, 3'b010, 3'b011);
        step(2'b00, 2'b01, 3'b100, 3'b101);
        step(2'b11, 2'b00, 3'b101, 3'b010);
        step(2'b10, 2'b01, 3'b001, 3'b001);

        // Mixed random traffic
        for (int n = 0; n < 400; n++) begin
            logic [1:0] a, b;
            logic [NP-1:0] h, l;
            a = 2'($urandom);
            b = 2'($urandom);
            h = NP'($urandom);
            l = (($urandom % 3) == 0) ? NP'($urandom) : ~h;
            step(a, b, h, l);
        end

        // R1: reset in the middle of traffic
        cell_p0_i = 2'b11;
        chain_hi_i = '0;
        chain_lo_i = '0;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 mid stage", int'(stage_o), 0);
        check("R1 mid chain_err", int'(chain_err_o), 0);
        check("R1 mid cell_err", int'(cell_err_o), 0);
        rst = 1'b0;
        step(2'b10, 2'b10, 3'b011, 3'b100);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule